// File: doc/BRIEF.md
# Commit-Aware Invalidation Responder

This block sits beside the private transactional cache of a core and answers each incoming coherence invalidation. It looks at whether the target line belongs to the local transaction's read set or write set, and at whether the local transaction is in its pre-commit phase. From these it decides to accept (ack) or refuse (nack) the invalidation. While the transaction is still executing, an invalidation never aborts it and never stalls it. The responder accepts the invalidation, tells the cache to drop the line, and asks for the line again, so that value validation can run when the data returns.

During pre-commit the local transaction must keep the permissions it has gathered. Invalidations to its lines are therefore refused, with one exception: the requester is itself committing and holds a strictly older timestamp. Timestamps are unique across the system, so two committing transactions can never refuse each other forever. A tie of timestamps breaks that guarantee. The block refuses the request and flags the tie as a protocol error.

Each decision comes out exactly one clock after the request is sampled. A new request may be presented on every cycle.

Top module: `inv_responder`

## Requirements
- R1: After reset, and until the first request is sampled, `resp_valid`, `resp_ack`, `resp_nack`, `refetch_valid` and `ts_clash` are all 0.
- R2: A request sampled with `inv_valid`=1 at a clock edge produces, after the next edge, `resp_valid`=1 with exactly one of `resp_ack`/`resp_nack` set and `resp_line` equal to the sampled `inv_line`. A request is accepted on every cycle.
- R3: On a cycle after a clock edge at which `inv_valid` was 0, `resp_valid`, `resp_ack`, `resp_nack`, `refetch_valid` and `ts_clash` are 0.
- R4: A request whose line is in neither set (`line_in_rd_set`=0 and `line_in_wr_set`=0) is acked with `refetch_valid`=0, in every phase and for any requester fields.
- R5: With `local_precommit`=0, a request to a line in the read set, the write set or both is acked with `refetch_valid`=1. This means the line is dropped and fetched again.
- R6: With `local_precommit`=1, a request to a line in either set from a requester with `inv_req_committing`=0 is nacked with `refetch_valid`=0, whatever the timestamps.
- R7: With `local_precommit`=1, a request to an in-set line from a committing requester whose `inv_req_ts` is numerically lower than `local_ts` (lower value = older = higher priority) is acked with `refetch_valid`=1.
- R8: With `local_precommit`=1, a request to an in-set line from a committing requester whose `inv_req_ts` is numerically higher than `local_ts` is nacked with `refetch_valid`=0.
- R9: With `local_precommit`=1, a request to an in-set line from a committing requester with `inv_req_ts` equal to `local_ts` is nacked and raises `ts_clash` for that response cycle. `ts_clash` is 0 for every other response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | An invalidation request is present this cycle |
| inv_line | input | LINE_W | Index of the targeted cache line |
| inv_req_committing | input | 1 | Requester is in its own pre-commit phase |
| inv_req_ts | input | TS_W | Requester's timestamp (lower is older) |
| local_ts | input | TS_W | Local transaction's timestamp |
| local_precommit | input | 1 | Local transaction is in its pre-commit phase |
| line_in_rd_set | input | 1 | Targeted line is in the local read set |
| line_in_wr_set | input | 1 | Targeted line is in the local write set |
| resp_valid | output | 1 | A decision is presented this cycle |
| resp_ack | output | 1 | The invalidation is accepted |
| resp_nack | output | 1 | The invalidation is refused |
| resp_line | output | LINE_W | Line index the decision refers to |
| refetch_valid | output | 1 | Drop the line and issue a new request for it |
| ts_clash | output | 1 | Equal timestamps met in a priority comparison |

## Verification
On every cycle, the assertions check the one-cycle latency, the ack/nack exclusivity, the echoed line index and the per-class decisions. These classes are out-of-set, executing phase, non-committing requester, older and younger committing requester, and tie. They also check that a refetch never comes with a nack and that a clash always comes with a nack. The bench's scenarios show what no single-cycle property can. These include the quiet state right after reset, long streams of back-to-back requests whose decisions must not bleed into each other, and the exact boundaries of the timestamp comparison (one apart, the extreme values, equality).

// File: rtl/inv_resp_pkg.sv
package inv_resp_pkg;

  typedef struct packed {
    logic ack;
    logic refetch;
    logic clash;
  } verdict_t;

  // Decision rule: out-of-set lines and executing transactions always accept;
  // pre-commit accepts only an older committing requester.
  function automatic verdict_t pick_verdict(
    input logic in_set,
    input logic precommit,
    input logic req_commit,
    input logic req_older,
    input logic ts_equal
  );
    verdict_t v;
    logic guarded;
    guarded   = in_set && precommit;
    v.ack     = !guarded || (req_commit && req_older);
    v.refetch = in_set && v.ack;
    v.clash   = guarded && req_commit && ts_equal;
    return v;
  endfunction

endpackage

// File: rtl/inv_ts_rank.sv
module inv_ts_rank #(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] req_ts,
  input  logic [TS_W-1:0] own_ts,
  output logic            req_older,
  output logic            ts_equal
);
  function automatic logic older_than(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    return a < b;
  endfunction

  always_comb begin
    req_older = older_than(req_ts, own_ts);
    ts_equal  = (req_ts == own_ts);
  end
endmodule

// File: rtl/inv_decide.sv
module inv_decide
  import inv_resp_pkg::*;
(
  input  logic     rd_hit,
  input  logic     wr_hit,
  input  logic     precommit,
  input  logic     req_commit,
  input  logic     req_older,
  input  logic     ts_equal,
  output logic     in_set,
  output verdict_t verdict
);
  always_comb begin
    in_set  = rd_hit || wr_hit;
    verdict = pick_verdict(in_set, precommit, req_commit, req_older, ts_equal);
  end
endmodule

// File: rtl/inv_resp_stage.sv
module inv_resp_stage
  import inv_resp_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [LINE_W-1:0] line_in,
  input  verdict_t          verdict,
  output logic              out_valid,
  output logic              out_ack,
  output logic              out_nack,
  output logic [LINE_W-1:0] out_line,
  output logic              out_refetch,
  output logic              out_clash
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_ack     <= 1'b0;
      out_nack    <= 1'b0;
      out_line    <= '0;
      out_refetch <= 1'b0;
      out_clash   <= 1'b0;
    end else begin
      out_valid   <= take;
      out_ack     <= take && verdict.ack;
      out_nack    <= take && !verdict.ack;
      out_refetch <= take && verdict.refetch;
      out_clash   <= take && verdict.clash;
      if (take) out_line <= line_in;
    end
  end
endmodule

// File: rtl/inv_responder.sv
module inv_responder
  import inv_resp_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  input  logic              inv_req_committing,
  input  logic [TS_W-1:0]   inv_req_ts,
  input  logic [TS_W-1:0]   local_ts,
  input  logic              local_precommit,
  input  logic              line_in_rd_set,
  input  logic              line_in_wr_set,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic              resp_nack,
  output logic [LINE_W-1:0] resp_line,
  output logic              refetch_valid,
  output logic              ts_clash
);
  // Named internal events, visible to the bound checker.
  logic     req_older;
  logic     ts_equal;
  logic     in_set;
  verdict_t verdict;

  inv_ts_rank #(.TS_W(TS_W)) u_rank (
    .req_ts    (inv_req_ts),
    .own_ts    (local_ts),
    .req_older (req_older),
    .ts_equal  (ts_equal)
  );

  inv_decide u_decide (
    .rd_hit     (line_in_rd_set),
    .wr_hit     (line_in_wr_set),
    .precommit  (local_precommit),
    .req_commit (inv_req_committing),
    .req_older  (req_older),
    .ts_equal   (ts_equal),
    .in_set     (in_set),
    .verdict    (verdict)
  );

  inv_resp_stage #(.LINE_W(LINE_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (inv_valid),
    .line_in     (inv_line),
    .verdict     (verdict),
    .out_valid   (resp_valid),
    .out_ack     (resp_ack),
    .out_nack    (resp_nack),
    .out_line    (resp_line),
    .out_refetch (refetch_valid),
    .out_clash   (ts_clash)
  );
endmodule

// File: rtl/inv_responder_chk.sv
module inv_responder_chk #(
  parameter int LINE_W = 10,
  parameter int TS_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inv_valid,
  input logic [LINE_W-1:0] inv_line,
  input logic              inv_req_committing,
  input logic [TS_W-1:0]   inv_req_ts,
  input logic [TS_W-1:0]   local_ts,
  input logic              local_precommit,
  input logic              line_in_rd_set,
  input logic              line_in_wr_set,
  input logic              resp_valid,
  input logic              resp_ack,
  input logic              resp_nack,
  input logic [LINE_W-1:0] resp_line,
  input logic              refetch_valid,
  input logic              ts_clash,
  input logic              req_older
);
  logic hit;
  assign hit = line_in_rd_set || line_in_wr_set;

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> resp_valid);
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_valid |=> !resp_valid && !resp_ack && !resp_nack && !refetch_valid && !ts_clash);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_ack, resp_nack}) == 1);
  p_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> resp_line == $past(inv_line));
  p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !hit |=> resp_ack && !refetch_valid);
  p_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && hit && !local_precommit |=> resp_ack && refetch_valid);
  p_nocommit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && hit && local_precommit && !inv_req_committing |=> resp_nack && !refetch_valid);
  p_older_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && hit && local_precommit && inv_req_committing && req_older |=> resp_ack && refetch_valid);
  p_younger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && hit && local_precommit && inv_req_committing && (inv_req_ts > local_ts) |=> resp_nack && !ts_clash);
  p_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clash |-> resp_nack);
  p_refetch_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refetch_valid |-> resp_ack);
endmodule

bind inv_responder inv_responder_chk #(.LINE_W(LINE_W), .TS_W(TS_W)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .inv_valid          (inv_valid),
  .inv_line           (inv_line),
  .inv_req_committing (inv_req_committing),
  .inv_req_ts         (inv_req_ts),
  .local_ts           (local_ts),
  .local_precommit    (local_precommit),
  .line_in_rd_set     (line_in_rd_set),
  .line_in_wr_set     (line_in_wr_set),
  .resp_valid         (resp_valid),
  .resp_ack           (resp_ack),
  .resp_nack          (resp_nack),
  .resp_line          (resp_line),
  .refetch_valid      (refetch_valid),
  .ts_clash           (ts_clash),
  .req_older          (req_older)
);

// File: tb/tb_inv_responder.sv
module tb_inv_responder;
  localparam int LINE_W = 10;
  localparam int TS_W   = 16;
  localparam logic [TS_W-1:0] TS_MAX = '1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              inv_valid;
  logic [LINE_W-1:0] inv_line;
  logic              inv_req_committing;
  logic [TS_W-1:0]   inv_req_ts;
  logic [TS_W-1:0]   local_ts;
  logic              local_precommit;
  logic              line_in_rd_set;
  logic              line_in_wr_set;
  logic              resp_valid, resp_ack, resp_nack, refetch_valid, ts_clash;
  logic [LINE_W-1:0] resp_line;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  inv_responder #(.LINE_W(LINE_W), .TS_W(TS_W)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected decision restated from the requirements.
  function automatic logic want_ack(input logic rd, input logic wr, input logic pc,
                                    input logic rc, input logic [TS_W-1:0] rts,
                                    input logic [TS_W-1:0] lts);
    if (!(rd || wr)) return 1'b1;        // R4
    if (!pc) return 1'b1;                // R5
    if (!rc) return 1'b0;                // R6
    return rts < lts;                    // R7 / R8 / R9
  endfunction

  task automatic drive(input logic [LINE_W-1:0] ln, input logic rd, input logic wr,
                       input logic pc, input logic rc, input logic [TS_W-1:0] rts,
                       input logic [TS_W-1:0] lts);
    inv_valid = 1'b1; inv_line = ln; line_in_rd_set = rd; line_in_wr_set = wr;
    local_precommit = pc; inv_req_committing = rc; inv_req_ts = rts; local_ts = lts;
  endtask

  task automatic expect_resp(input string tag, input logic [LINE_W-1:0] ln, input logic rd,
                             input logic wr, input logic pc, input logic rc,
                             input logic [TS_W-1:0] rts, input logic [TS_W-1:0] lts);
    logic a;
    a = want_ack(rd, wr, pc, rc, rts, lts);
    chk({tag, " valid"}, 32'(resp_valid), 32'd1);
    chk({tag, " ack"}, 32'(resp_ack), 32'(a));
    chk({tag, " nack"}, 32'(resp_nack), 32'(!a));
    chk({tag, " line"}, 32'(resp_line), 32'(ln));
    chk({tag, " refetch"}, 32'(refetch_valid), 32'((rd || wr) && a));
    chk({tag, " clash"}, 32'(ts_clash), 32'((rd || wr) && pc && rc && rts == lts));
  endtask

  // One request: drive at a falling edge, sample at the next falling edge.
  task automatic send(input string tag, input logic [LINE_W-1:0] ln, input logic rd,
                      input logic wr, input logic pc, input logic rc,
                      input logic [TS_W-1:0] rts, input logic [TS_W-1:0] lts);
    @(negedge clk);
    drive(ln, rd, wr, pc, rc, rts, lts);
    @(negedge clk);
    expect_resp(tag, ln, rd, wr, pc, rc, rts, lts);
    inv_valid = 1'b0;
  endtask

  task automatic t_reset_quiet();
    @(negedge clk);
    chk("R1 valid", 32'(resp_valid), 0);
    chk("R1 ack", 32'(resp_ack), 0);
    chk("R1 nack", 32'(resp_nack), 0);
    chk("R1 refetch", 32'(refetch_valid), 0);
    chk("R1 clash", 32'(ts_clash), 0);
  endtask

  task automatic t_idle();
    // inputs wiggle with inv_valid low: nothing may come out (R3)
    @(negedge clk);
    inv_valid = 1'b0; line_in_rd_set = 1'b1; local_precommit = 1'b1; inv_line = 10'h155;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 valid", 32'(resp_valid), 0);
      chk("R3 refetch", 32'(refetch_valid), 0);
      chk("R3 clash", 32'(ts_clash), 0);
    end
  endtask

  task automatic t_outside();
    send("R4 running",   10'h001, 0, 0, 0, 0, 16'd3, 16'd9);
    send("R4 precommit", 10'h002, 0, 0, 1, 0, 16'd3, 16'd9);
    send("R4 pc younger", 10'h003, 0, 0, 1, 1, 16'd20, 16'd9);
    send("R4 pc equal",  10'h004, 0, 0, 1, 1, 16'd9, 16'd9);
  endtask

  task automatic t_running();
    send("R5 rd",   10'h010, 1, 0, 0, 0, 16'd50, 16'd9);
    send("R5 wr",   10'h011, 0, 1, 0, 1, 16'd50, 16'd9);
    send("R5 both", 10'h3FF, 1, 1, 0, 1, 16'd9,  16'd9);
  endtask

  task automatic t_nocommit();
    send("R6 older",   10'h020, 1, 0, 1, 0, 16'd1,  16'd9);
    send("R6 younger", 10'h021, 0, 1, 1, 0, 16'd30, 16'd9);
  endtask

  task automatic t_older();
    send("R7 gap1",  10'h030, 1, 0, 1, 1, 16'd8, 16'd9);
    send("R7 zero",  10'h031, 0, 1, 1, 1, 16'd0, TS_MAX);
  endtask

  task automatic t_younger();
    send("R8 gap1", 10'h040, 1, 0, 1, 1, 16'd10, 16'd9);
    send("R8 max",  10'h041, 1, 1, 1, 1, TS_MAX, 16'd0);
  endtask

  task automatic t_equal();
    send("R9 tie",     10'h050, 1, 0, 1, 1, 16'd77, 16'd77);
    send("R9 tie max", 10'h051, 0, 1, 1, 1, TS_MAX, TS_MAX);
    send("R9 no clash after", 10'h052, 1, 0, 1, 1, 16'd76, 16'd77);
  endtask

  task automatic t_back2back();
    // A new request every cycle; each response must match its own request (R2).
    logic [LINE_W-1:0] pl; logic prd, pwr, ppc, prc; logic [TS_W-1:0] prt, plt;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      logic [LINE_W-1:0] ln; logic rd, wr, pc, rc; logic [TS_W-1:0] rt, lt;
      ln = LINE_W'(10'h100 + i); rd = i[0]; wr = i[1]; pc = i[2] ^ i[0];
      rc = !i[1]; rt = TS_W'(i * 3); lt = 16'd10;
      if (i > 0) expect_resp("R2 b2b", pl, prd, pwr, ppc, prc, prt, plt);
      drive(ln, rd, wr, pc, rc, rt, lt);
      pl = ln; prd = rd; pwr = wr; ppc = pc; prc = rc; prt = rt; plt = lt;
      @(negedge clk);
    end
    expect_resp("R2 b2b last", pl, prd, pwr, ppc, prc, prt, plt);
    inv_valid = 1'b0;
    @(negedge clk);
    chk("R3 after stream", 32'(resp_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; inv_valid = 1'b0; inv_line = '0; inv_req_committing = 1'b0;
    inv_req_ts = '0; local_ts = '0; local_precommit = 1'b0;
    line_in_rd_set = 1'b0; line_in_wr_set = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_quiet();
    t_idle();
    t_outside();
    t_running();
    t_nocommit();
    t_older();
    t_younger();
    t_equal();
    t_back2back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule